// File: doc/BRIEF.md
# PCI Interrupt Line to Global Interrupt Router

This block takes eight level-sensitive PCI interrupt request lines (A through H) and one ACPI system-control interrupt (SCI). It places them onto a 24-wide vector of global interrupt outputs. Outputs 0 to 15 feed a legacy 8259-style controller. Outputs 16 to 23 feed an I/O APIC. Each request line always drives its own fixed APIC output. At the same time it drives one programmable legacy output, unless its route is disabled.

Four INTx pins from devices behind an internal bridge share request lines E to H. A small write port holds one routing byte per request line and one SCI select field. The outputs are combinational from the inputs and the registered routing state. An input change shows on the outputs in the same cycle. A register write shows on the outputs after the clock edge that accepts it.

Top module: `pirq_gsi_router`

## Requirements
- R1: After reset, every routing byte is 0x80 (disabled) and the SCI select is 0, so no request line reaches outputs 0-15 and an asserted SCI appears on output 9.
- R2: Request line n (n = 0..7, A..H) always drives output 16+n, whatever its routing byte holds, and no other request line drives that output.
- R3: A routing byte uses bits [3:0] as the legacy output number and bit 7 as the disable bit. Legacy output p is the OR of every request line whose byte selects p and has bit 7 clear.
- R4: Bridge INTx pins 0..3 (INTA..INTD) are ORed into request lines E..H (n = 4..7) before any routing.
- R5: The SCI select (bits [2:0] written at address 8) decodes 0..6 to outputs 9, 10, 11, 20, 21, 22, 23. The SCI level is ORed into that one output only.
- R6: SCI select value 7 means no target: the SCI input then has no effect on any output.
- R7: A write to address 8 with a value different from the current select, accepted while the SCI input is high, keeps the SCI off every output for the following cycle. The SCI then appears on the new target. A write of the same value causes no such gap.
- R8: Routing bytes sit at addresses 0..7 (address n for request line n). Writes to addresses 9..15 change nothing.
- R9: A change on a request, INTx or SCI input appears on the outputs in the same cycle. A routing write takes effect in the cycle after the edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pirq_in | input | 8 | Request line levels, bit n = line A+n |
| bridge_intx | input | 4 | Bridge INTA..INTD levels |
| sci_in | input | 1 | SCI level |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 8 | Register write data |
| gsi_out | output | 24 | Global interrupt output levels |

## Verification
The hardest situation to reach is a retarget of the SCI while it is asserted. The one-cycle blank on both the old and the new output is visible only if the SCI input is high at the exact edge that accepts the select write, and only if no request line masks the affected outputs. The stimulus holds every request line low and raises the SCI before the write. It then samples the outputs in the cycle right after the write and again one cycle later. It repeats the write with an unchanged value to show that no blank occurs.

// File: rtl/pirq_router_pkg.sv
// Package: shared constants and types for the interrupt router.
// Assumes 16 legacy pins and one APIC pin per request line.
package pirq_router_pkg;
    localparam int NUM_PIRQ   = 8;
    localparam int NUM_LEGACY = 16;
    localparam int NUM_INTX   = 4;
    localparam int NUM_GSI    = NUM_LEGACY + NUM_PIRQ;
    localparam int PIN_W      = $clog2(NUM_LEGACY);
    localparam int GSI_W      = $clog2(NUM_GSI);
    localparam int ADDR_W     = 4;
    localparam int SEL_W      = 3;
    localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(NUM_PIRQ);

    typedef struct packed {
        logic             dis;
        logic [PIN_W-1:0] pin;
    } route_t;

    localparam route_t ROUTE_RESET = '{dis: 1'b1, pin: '0};
endpackage

// File: rtl/pirq_route_regs.sv
// Module: routing state registers.
// Holds one route per request line, the SCI select and the retarget-gap flag.
// Assumes a single write port; unknown addresses are dropped.
module pirq_route_regs
    import pirq_router_pkg::*;
#(
    parameter int NPIRQ = NUM_PIRQ
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              sci_in,
    output route_t            route_q [NPIRQ],
    output logic [SEL_W-1:0]  sci_sel_q,
    output logic              sci_gap_q
);
    logic unused_wdata_bits;
    assign unused_wdata_bits = ^cfg_wdata[6:PIN_W];

    logic sel_hit;
    assign sel_hit = cfg_we && (cfg_addr == SEL_ADDR);

    // Per-line route byte storage.
    for (genvar n = 0; n < NPIRQ; n++) begin : g_route
        always_ff @(posedge clk) begin
            if (!rst_n)
                route_q[n] <= ROUTE_RESET;
            else if (cfg_we && cfg_addr == ADDR_W'(n))
                route_q[n] <= '{dis: cfg_wdata[7], pin: cfg_wdata[PIN_W-1:0]};
        end
    end

    // SCI select storage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sci_sel_q <= '0;
        else if (sel_hit)
            sci_sel_q <= cfg_wdata[SEL_W-1:0];
    end

    // One-cycle blank when the SCI target moves while it is asserted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sci_gap_q <= 1'b0;
        else
            sci_gap_q <= sel_hit && sci_in && (cfg_wdata[SEL_W-1:0] != sci_sel_q);
    end
endmodule

// File: rtl/pirq_sci_decode.sv
// Module: turns the SCI select code into a one-hot output vector.
// Assumes codes 0..6 name a pin and code 7 names none.
module pirq_sci_decode
    import pirq_router_pkg::*;
#(
    parameter int NGSI = NUM_GSI
) (
    input  logic [SEL_W-1:0] sel,
    input  logic             sci_in,
    input  logic             gap,
    output logic [NGSI-1:0]  sci_vec
);
    logic             valid;
    logic [GSI_W-1:0] idx;

    // Code to pin number lookup.
    always_comb begin
        valid = 1'b1;
        unique case (sel)
            3'd0: idx = GSI_W'(9);
            3'd1: idx = GSI_W'(10);
            3'd2: idx = GSI_W'(11);
            3'd3: idx = GSI_W'(20);
            3'd4: idx = GSI_W'(21);
            3'd5: idx = GSI_W'(22);
            3'd6: idx = GSI_W'(23);
            default: begin
                idx   = '0;
                valid = 1'b0;
            end
        endcase
    end

    // Place the SCI level on the selected pin unless blanked.
    always_comb begin
        sci_vec = '0;
        if (valid && sci_in && !gap)
            sci_vec[idx] = 1'b1;
    end
endmodule

// File: rtl/pirq_gsi_combine.sv
// Module: OR network from request lines to APIC and legacy pins.
// Assumes request lines are already merged with bridge INTx levels.
module pirq_gsi_combine
    import pirq_router_pkg::*;
#(
    parameter int NPIRQ = NUM_PIRQ,
    parameter int NLEG  = NUM_LEGACY
) (
    input  logic [NPIRQ-1:0]      pirq_eff,
    input  route_t                route [NPIRQ],
    input  logic [NLEG+NPIRQ-1:0] sci_vec,
    output logic [NLEG+NPIRQ-1:0] gsi
);
    logic [NLEG-1:0] legacy;

    // Legacy pin p collects every enabled line routed to it.
    for (genvar p = 0; p < NLEG; p++) begin : g_leg
        always_comb begin
            legacy[p] = 1'b0;
            for (int n = 0; n < NPIRQ; n++)
                if (!route[n].dis && route[n].pin == PIN_W'(p))
                    legacy[p] = legacy[p] | pirq_eff[n];
        end
    end

    // Fixed APIC pins above the legacy range, SCI merged last.
    assign gsi = {pirq_eff, legacy} | sci_vec;
endmodule

// File: rtl/pirq_gsi_router.sv
// Module: top of the request-line to global-interrupt router.
// Assumes level-sensitive inputs synchronous to clk; outputs are combinational.
module pirq_gsi_router
    import pirq_router_pkg::*;
#(
    parameter int NPIRQ = NUM_PIRQ,
    parameter int NLEG  = NUM_LEGACY,
    parameter int NINTX = NUM_INTX
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPIRQ-1:0]        pirq_in,
    input  logic [NINTX-1:0]        bridge_intx,
    input  logic                    sci_in,
    input  logic                    cfg_we,
    input  logic [ADDR_W-1:0]       cfg_addr,
    input  logic [7:0]              cfg_wdata,
    output logic [NLEG+NPIRQ-1:0]   gsi_out
);
    localparam int NGSI = NLEG + NPIRQ;

    route_t             route_q [NPIRQ];
    logic [SEL_W-1:0]   sci_sel_q;
    logic               sci_gap_q;
    logic [NPIRQ-1:0]   pirq_eff;
    logic [NGSI-1:0]    sci_vec;

    // Bridge INTx pins share the top request lines.
    assign pirq_eff = pirq_in | {bridge_intx, {(NPIRQ-NINTX){1'b0}}};

    pirq_route_regs #(.NPIRQ(NPIRQ)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .sci_in(sci_in), .route_q(route_q),
        .sci_sel_q(sci_sel_q), .sci_gap_q(sci_gap_q)
    );

    pirq_sci_decode #(.NGSI(NGSI)) u_sci (
        .sel(sci_sel_q), .sci_in(sci_in), .gap(sci_gap_q), .sci_vec(sci_vec)
    );

    pirq_gsi_combine #(.NPIRQ(NPIRQ), .NLEG(NLEG)) u_comb (
        .pirq_eff(pirq_eff), .route(route_q), .sci_vec(sci_vec), .gsi(gsi_out)
    );
endmodule

// File: rtl/pirq_gsi_router_chk.sv
// Checker: temporal properties of the router, bound to its top.
module pirq_gsi_router_chk
    import pirq_router_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        pirq_in,
    input logic [3:0]        bridge_intx,
    input logic              sci_in,
    input logic              cfg_we,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [7:0]        cfg_wdata,
    input logic [23:0]       gsi_out,
    input logic [SEL_W-1:0]  sci_sel
);
    logic [7:0] eff;
    assign eff = pirq_in | {bridge_intx, 4'b0};
    logic unused_chk_bits;
    assign unused_chk_bits = ^cfg_wdata[7:SEL_W];

    // R2
    apic_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eff & ~gsi_out[23:16]) == 8'h00);

    // R5
    sci_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eff == 8'h00) |-> ($countones(gsi_out) <= 1));

    // R7
    retarget_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == SEL_ADDR && cfg_wdata[SEL_W-1:0] != sci_sel && sci_in)
        |=> (eff != 8'h00 || gsi_out == 24'h0));

    // R1
    reset_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n) && eff == 8'h00) |-> (gsi_out == (sci_in ? 24'h000200 : 24'h0)));
endmodule

bind pirq_gsi_router pirq_gsi_router_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pirq_in(pirq_in), .bridge_intx(bridge_intx),
    .sci_in(sci_in), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .gsi_out(gsi_out), .sci_sel(sci_sel_q)
);

// File: tb/sim_pirq_gsi_router.sv
module sim_pirq_gsi_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pirq_in = '0;
    logic [3:0]  bridge_intx = '0;
    logic        sci_in = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [23:0] gsi_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pirq_gsi_router u0 (
        .clk(clk), .rst_n(rst_n), .pirq_in(pirq_in), .bridge_intx(bridge_intx),
        .sci_in(sci_in), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .gsi_out(gsi_out)
    );

    // {pirq, intx, sci, expected}; routes A,B->5 C->10 D off E->3 F->9 G->15 H->0, SCI on 9
    localparam int NVEC = 13;
    localparam logic [36:0] VEC [NVEC] = '{
        {8'h00, 4'h0, 1'b0, 24'h000000},
        {8'h01, 4'h0, 1'b0, 24'h010020},
        {8'h02, 4'h0, 1'b0, 24'h020020},
        {8'h03, 4'h0, 1'b0, 24'h030020},
        {8'h08, 4'h0, 1'b0, 24'h080000},
        {8'h04, 4'h0, 1'b0, 24'h040400},
        {8'h00, 4'h0, 1'b1, 24'h000200},
        {8'h20, 4'h0, 1'b0, 24'h200200},
        {8'h20, 4'h0, 1'b1, 24'h200200},
        {8'h00, 4'h1, 1'b0, 24'h100008},
        {8'h00, 4'h8, 1'b0, 24'h800001},
        {8'h40, 4'h0, 1'b0, 24'h408000},
        {8'hFF, 4'h0, 1'b0, 24'hFF8629}
    };

    task automatic check(input string req, input logic [23:0] exp);
        checks++;
        if (gsi_out !== exp) begin
            errors++;
            $display("FAIL %s: gsi_out=%06h expected=%06h", req, gsi_out, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic drive(input logic [7:0] p, input logic [3:0] x, input logic s);
        @(negedge clk);
        pirq_in = p; bridge_intx = x; sci_in = s;
        #2;
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: all routes disabled, default SCI target 9
        drive(8'hFF, 4'h0, 1'b0);
        check("R1", 24'hFF0000);
        drive(8'h00, 4'h0, 1'b1);
        check("R1", 24'h000200);
        drive(8'h00, 4'h0, 1'b0);

        wr(4'd0, 8'h05); wr(4'd1, 8'h05); wr(4'd2, 8'h0A); wr(4'd3, 8'h83);
        wr(4'd4, 8'h03); wr(4'd5, 8'h09); wr(4'd6, 8'h0F); wr(4'd7, 8'h00);

        // R2 R3 R4 R9: vector table
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][36:29], VEC[i][28:25], VEC[i][24]);
            check("R2/R3/R4/R9 vector", VEC[i][23:0]);
        end
        drive(8'h00, 4'h0, 1'b0);

        // R9: route write takes effect after its edge
        pirq_in = 8'h01; #1;
        wr(4'd0, 8'h07);
        check("R9", 24'h010080);

        // R8: write at unused address changes nothing
        wr(4'd12, 8'h00);
        check("R8", 24'h010080);
        drive(8'h00, 4'h0, 1'b0);

        // R5: SCI select 3 -> output 20 only
        wr(4'd8, 8'h03);
        drive(8'h00, 4'h0, 1'b1);
        check("R5", 24'h100000);
        drive(8'h00, 4'h0, 1'b0);

        // R6: select 7 -> SCI ignored
        wr(4'd8, 8'h07);
        drive(8'h00, 4'h0, 1'b1);
        check("R6", 24'h000000);
        drive(8'h00, 4'h0, 1'b0);
        wr(4'd8, 8'h00);

        // R7: retarget while asserted: gap cycle then new pin
        drive(8'h00, 4'h0, 1'b1);
        check("R7", 24'h000200);
        wr(4'd8, 8'h01);
        check("R7", 24'h000000);
        @(posedge clk); #1;
        check("R7", 24'h000400);
        // R7: same-value write, no gap
        wr(4'd8, 8'h01);
        check("R7", 24'h000400);
        drive(8'h00, 4'h0, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule